// File: doc/BRIEF.md
# Protection Information Verifier

This block checks the protection tuple carried in each sector's metadata against values it works out itself. The tuple holds a guard CRC, an application tag and a reference tag. A command is opened with a one-cycle start pulse that carries the check settings. The host then streams the command's extended sectors one byte per valid cycle. Each sector is a fixed number of data bytes followed by a fixed number of metadata bytes.

For each sector the block runs a CRC over the data, and over the metadata bytes that come before the tuple when the tuple sits at the end of the metadata. When the sector's last byte arrives, the block judges the sector. The first sector that fails sets the command status, and the block drops the rest of the command's bytes so that the stream stays in step for the next command.

Two guard formats are supported, chosen per command:
- a 16-bit CRC with an 8-byte tuple;
- a 64-bit CRC with a 16-byte tuple.

The protection type selects how the reference tag advances from sector to sector and which tag values switch checking off for a sector.

Top module: `pi_verify`

## Requirements
- R1: After reset, and while no command has started, `busy`=0, `done`=0, `status`=0 and `no_retry`=0. When a command ends, `done`=1 and `status` hold unchanged until the next accepted `cmd_start`. Bytes offered while idle are ignored.
- R2: With `cmd_fmt64`=0, the guard is a CRC with polynomial 0x8BB7 and initial value 0. It is computed MSB first, with no reflection and no final inversion. It covers the data bytes, then any metadata bytes before the tuple. The tuple is 8 bytes, big-endian: guard (2 bytes), application tag (2), reference tag (4).
- R3: With `cmd_fmt64`=1, the guard is a reflected CRC with polynomial 0x9A6C9329AC4BC9B5, initial value all ones and a final inversion. When metadata bytes come before the tuple, the running value is inverted once before the first of those bytes is absorbed. The tuple is 16 bytes, big-endian: guard (8 bytes), application tag (2), reference tag (6).
- R4: With `cmd_tuple_first`=1, the tuple starts at metadata byte 0 and the guard covers only the data. Otherwise the tuple occupies the last tuple-sized bytes of the metadata.
- R5: Status codes are 0 success, 1 guard error, 2 application tag error, 3 reference tag error, 4 invalid protection settings. `cmd_chk` bit 2 enables the guard check, bit 1 the application tag check and bit 0 the reference tag check. Only enabled checks run. They are evaluated guard first, then application tag, then reference tag, and the first mismatch sets the code.
- R6: The application tag check compares (received AND `cmd_app_msk`) with (`cmd_app_exp` AND `cmd_app_msk`).
- R7: For protection types 0, 1 and 2, a received application tag of 0xFFFF makes the sector pass with no check at all.
- R8: For type 3, a sector skips all checks only when the received application tag is 0xFFFF and the received reference tag is all ones (32 bits with the 16-bit guard, 48 bits with the 64-bit guard).
- R9: The expected reference tag starts at `cmd_ref_start` and rises by one after every passing sector, except for type 3, where it stays constant.
- R10: For type 1 with reference checking enabled, `cmd_ref_start` is compared at start with the low 32 bits (16-bit guard) or low 48 bits (64-bit guard) of `cmd_slba`. A mismatch sets status 4 with `no_retry`=1 and checks no sector.
- R11: A guard mismatch on sector 0 of a command whose `cmd_slba` is 0 is forgiven, and that sector passes, when all of its data bytes are zero. A guard mismatch on any other sector, or with any other `cmd_slba`, is not forgiven.
- R12: The first failing sector fixes the status. The remaining bytes of the command are consumed without effect. `done` rises after the last byte of the last sector, so the next command lines up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Opens a command when the block is idle; ignored while busy |
| cmd_chk | input | 3 | Check enables: bit 2 guard, bit 1 application tag, bit 0 reference tag |
| cmd_app_exp | input | 16 | Expected application tag |
| cmd_app_msk | input | 16 | Application tag compare mask |
| cmd_ref_start | input | REF_W | Expected reference tag of the first sector |
| cmd_slba | input | LBA_W | Starting logical block address |
| cmd_nlb_m1 | input | NLB_W | Number of sectors minus one |
| cmd_pi_type | input | 2 | Protection type 0..3 |
| cmd_fmt64 | input | 1 | 1 selects the 64-bit guard format |
| cmd_tuple_first | input | 1 | 1 places the tuple at the start of the metadata |
| in_vld | input | 1 | A stream byte is present |
| in_byte | input | 8 | Stream byte (data, then metadata, per sector) |
| busy | output | 1 | A command is in progress |
| done | output | 1 | The last command has ended; held until the next start |
| status | output | 3 | Command status code |
| no_retry | output | 1 | Set together with status 4 |

## Verification
Two events can fall on the same byte. When the final sector of a command is the one that fails, its verdict and the end of the command both happen on that sector's last byte. The bench provokes this by corrupting only the reference tag of the last sector of a three-sector command. It then expects, in one sample, the reference error code and `done` raised, with no drain phase. It contrasts this with a failure in a middle sector, where the remaining bytes must be drained before `done` rises. A clean command issued right afterwards must pass, which shows that byte alignment survived both paths.

// File: rtl/pi_verify_pkg.sv
package pi_verify_pkg;

   typedef enum logic [2:0] {
      PV_OK       = 3'd0,
      PV_GUARD    = 3'd1,
      PV_APPTAG   = 3'd2,
      PV_REFTAG   = 3'd3,
      PV_BADPARAM = 3'd4
   } pv_status_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHECK = 2'd1,
      ST_DRAIN = 2'd2
   } pv_state_e;

   typedef struct packed {
      logic        chk_guard;
      logic        chk_app;
      logic        chk_ref;
      logic [1:0]  pi_type;
      logic        fmt64;
      logic        tup_first;
      logic [15:0] app_exp;
      logic [15:0] app_msk;
   } pv_cfg_t;

   localparam logic [15:0] PV_POLY16  = 16'h8BB7;
   localparam logic [63:0] PV_POLY64R = 64'h9A6C9329AC4BC9B5;

   function automatic logic [15:0] pv_step16(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {b, 8'h00};
      for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ PV_POLY16) : (r << 1);
      return r;
   endfunction

   function automatic logic [63:0] pv_step64(input logic [63:0] c, input logic [7:0] b);
      logic [63:0] r;
      r = c ^ {56'h0, b};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ PV_POLY64R) : (r >> 1);
      return r;
   endfunction

endpackage

// File: rtl/pi_guard_acc.sv
module pi_guard_acc
   import pi_verify_pkg::*;
#(
   parameter int GUARD64_EN = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        absorb,
   input  logic        flip,
   input  logic [7:0]  byte_in,
   output logic [15:0] guard16,
   output logic [63:0] guard64
);

   logic [15:0] c16;

   always_ff @(posedge clk) begin
      if (!rst_n)      c16 <= '0;
      else if (clr)    c16 <= '0;
      else if (absorb) c16 <= pv_step16(c16, byte_in);
   end

   assign guard16 = c16;

   generate
      if (GUARD64_EN != 0) begin : g_crc64
         logic [63:0] c64;
         logic [63:0] seed;
         assign seed = flip ? ~c64 : c64;
         always_ff @(posedge clk) begin
            if (!rst_n)      c64 <= '1;
            else if (clr)    c64 <= '1;
            else if (absorb) c64 <= pv_step64(seed, byte_in);
         end
         assign guard64 = ~c64;
      end else begin : g_no_crc64
         logic unused_flip;
         assign unused_flip = flip;
         assign guard64 = '0;
      end
   endgenerate

endmodule

// File: rtl/pi_tuple_cap.sv
module pi_tuple_cap #(
   parameter int TUP_BYTES = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   shift,
   input  logic [7:0]             byte_in,
   output logic [TUP_BYTES*8-1:0] tup_nxt
);

   localparam int TB = TUP_BYTES * 8;

   logic [TB-1:0] tup;

   assign tup_nxt = shift ? {tup[TB-9:0], byte_in} : tup;

   always_ff @(posedge clk) begin
      if (!rst_n)   tup <= '0;
      else if (clr) tup <= '0;
      else          tup <= tup_nxt;
   end

endmodule

// File: rtl/pi_block_judge.sv
module pi_block_judge
   import pi_verify_pkg::*;
#(
   parameter int REF_W = 48
) (
   input  pv_cfg_t         cfg,
   input  logic [127:0]    tup,
   input  logic [15:0]     guard16,
   input  logic [63:0]     guard64,
   input  logic [REF_W-1:0] exp_ref,
   input  logic            zero_first,
   output pv_status_e      verdict
);

   logic [15:0]      app_rx;
   logic [REF_W-1:0] ref_rx;
   logic             ref_ones;
   logic             guard_bad;
   logic             esc;

   always_comb begin
      if (cfg.fmt64) begin
         app_rx    = tup[63:48];
         ref_rx    = REF_W'(tup[47:0]);
         ref_ones  = &tup[47:0];
         guard_bad = tup[127:64] != guard64;
      end else begin
         app_rx    = tup[47:32];
         ref_rx    = REF_W'(tup[31:0]);
         ref_ones  = &tup[31:0];
         guard_bad = tup[63:48] != guard16;
      end
      esc = (cfg.pi_type == 2'd3) ? (ref_ones && app_rx == 16'hFFFF)
                                  : (app_rx == 16'hFFFF);
      if (esc)
         verdict = PV_OK;
      else if (cfg.chk_guard && guard_bad)
         verdict = zero_first ? PV_OK : PV_GUARD;
      else if (cfg.chk_app && ((app_rx & cfg.app_msk) != (cfg.app_exp & cfg.app_msk)))
         verdict = PV_APPTAG;
      else if (cfg.chk_ref && ref_rx != exp_ref)
         verdict = PV_REFTAG;
      else
         verdict = PV_OK;
   end

endmodule

// File: rtl/pi_verify.sv
module pi_verify
   import pi_verify_pkg::*;
#(
   parameter int SECT_BYTES = 64,
   parameter int META_BYTES = 24,
   parameter int NLB_W      = 8,
   parameter int REF_W      = 48,
   parameter int LBA_W      = 64,
   parameter int GUARD64_EN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic [2:0]       cmd_chk,
   input  logic [15:0]      cmd_app_exp,
   input  logic [15:0]      cmd_app_msk,
   input  logic [REF_W-1:0] cmd_ref_start,
   input  logic [LBA_W-1:0] cmd_slba,
   input  logic [NLB_W-1:0] cmd_nlb_m1,
   input  logic [1:0]       cmd_pi_type,
   input  logic             cmd_fmt64,
   input  logic             cmd_tuple_first,
   input  logic             in_vld,
   input  logic [7:0]       in_byte,
   output logic             busy,
   output logic             done,
   output logic [2:0]       status,
   output logic             no_retry
);

   localparam int EXT_BYTES = SECT_BYTES + META_BYTES;
   localparam int POS_W     = $clog2(EXT_BYTES);

   initial begin
      assert (META_BYTES >= ((GUARD64_EN != 0) ? 16 : 8)) else $error("metadata too small for tuple");
      assert (SECT_BYTES >= 1) else $error("sector size must be positive");
      assert (REF_W >= 48 && LBA_W >= REF_W) else $error("tag or address width too small");
   end

   pv_state_e        st;
   pv_cfg_t          cfg;
   logic [NLB_W-1:0] nlb_m1;
   logic [NLB_W-1:0] blk;
   logic [REF_W-1:0] exp_ref;
   logic [POS_W-1:0] pos;
   logic             data_nz;
   logic             lba0;
   pv_status_e       status_q;
   logic             done_q;
   logic             noretry_q;

   // command acceptance and start-time validation of the reference seed
   logic             cmd_accept;
   logic [LBA_W-1:0] slba_low;
   logic             pre_bad;

   assign cmd_accept = cmd_start && (st == ST_IDLE);
   assign slba_low   = cmd_fmt64 ? (cmd_slba & LBA_W'(48'hFFFF_FFFF_FFFF))
                                 : (cmd_slba & LBA_W'(32'hFFFF_FFFF));
   assign pre_bad    = (cmd_pi_type == 2'd1) && cmd_chk[0] &&
                       (slba_low != LBA_W'(cmd_ref_start));

   // byte classification within one extended sector
   logic             take;
   logic             is_data;
   logic [POS_W-1:0] midx;
   logic [POS_W-1:0] toff;
   logic [POS_W-1:0] tlen;
   logic             in_prefix;
   logic             in_tuple;
   logic             last_pos;
   logic             last_blk;

   assign take      = in_vld && (st != ST_IDLE);
   assign is_data   = pos < POS_W'(SECT_BYTES);
   assign midx      = pos - POS_W'(SECT_BYTES);
   assign tlen      = cfg.fmt64 ? POS_W'(16) : POS_W'(8);
   assign toff      = cfg.tup_first ? '0 :
                      (cfg.fmt64 ? POS_W'(META_BYTES - 16) : POS_W'(META_BYTES - 8));
   assign in_prefix = !is_data && (midx < toff);
   assign in_tuple  = !is_data && (midx >= toff) && (midx < toff + tlen);
   assign last_pos  = pos == POS_W'(EXT_BYTES - 1);
   assign last_blk  = blk == nlb_m1;

   logic sect_clr;
   logic absorb;
   logic flip;
   logic shift;

   assign sect_clr = cmd_accept || (take && last_pos);
   assign absorb   = take && (st == ST_CHECK) && (is_data || in_prefix);
   assign flip     = cfg.fmt64 && in_prefix && (midx == '0);
   assign shift    = take && (st == ST_CHECK) && in_tuple;

   logic [15:0]  guard16;
   logic [63:0]  guard64;
   logic [127:0] tup_nxt;
   pv_status_e   verdict;

   pi_guard_acc #(.GUARD64_EN(GUARD64_EN)) u_guard (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (sect_clr),
      .absorb  (absorb),
      .flip    (flip),
      .byte_in (in_byte),
      .guard16 (guard16),
      .guard64 (guard64)
   );

   pi_tuple_cap #(.TUP_BYTES(16)) u_tuple (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (sect_clr),
      .shift   (shift),
      .byte_in (in_byte),
      .tup_nxt (tup_nxt)
   );

   pi_block_judge #(.REF_W(REF_W)) u_judge (
      .cfg        (cfg),
      .tup        (tup_nxt),
      .guard16    (guard16),
      .guard64    (guard64),
      .exp_ref    (exp_ref),
      .zero_first (lba0 && (blk == '0) && !data_nz),
      .verdict    (verdict)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cfg       <= '0;
         nlb_m1    <= '0;
         blk       <= '0;
         exp_ref   <= '0;
         pos       <= '0;
         data_nz   <= 1'b0;
         lba0      <= 1'b0;
         status_q  <= PV_OK;
         done_q    <= 1'b0;
         noretry_q <= 1'b0;
      end else if (cmd_accept) begin
         cfg       <= '{chk_guard: cmd_chk[2], chk_app: cmd_chk[1], chk_ref: cmd_chk[0],
                        pi_type: cmd_pi_type, fmt64: cmd_fmt64, tup_first: cmd_tuple_first,
                        app_exp: cmd_app_exp, app_msk: cmd_app_msk};
         nlb_m1    <= cmd_nlb_m1;
         blk       <= '0;
         exp_ref   <= cmd_ref_start;
         pos       <= '0;
         data_nz   <= 1'b0;
         lba0      <= cmd_slba == '0;
         done_q    <= 1'b0;
         status_q  <= pre_bad ? PV_BADPARAM : PV_OK;
         noretry_q <= pre_bad;
         st        <= pre_bad ? ST_DRAIN : ST_CHECK;
      end else if (take) begin
         pos <= last_pos ? '0 : pos + 1'b1;
         if ((st == ST_CHECK) && is_data && (in_byte != 8'h00)) data_nz <= 1'b1;
         if (last_pos) begin
            data_nz <= 1'b0;
            blk     <= blk + 1'b1;
            if ((st == ST_CHECK) && (verdict != PV_OK)) begin
               status_q <= verdict;
               st       <= ST_DRAIN;
            end else if ((st == ST_CHECK) && (cfg.pi_type != 2'd3)) begin
               exp_ref <= exp_ref + 1'b1;
            end
            if (last_blk) begin
               st     <= ST_IDLE;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy     = st != ST_IDLE;
   assign done     = done_q;
   assign status   = status_q;
   assign no_retry = noretry_q;

   // R1: a finished command keeps its result until a new start
   p_result_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cmd_start) |=> (done && $stable(status)));

   // R1: an accepted start withdraws the previous completion
   p_start_clears_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !busy) |=> !done);

   // R10: a bad reference seed is reported before any sector
   p_seed_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !busy && cmd_pi_type == 2'd1 && cmd_chk[0] &&
       (slba_low != LBA_W'(cmd_ref_start))) |=> (status == 3'd4 && no_retry));

   // R9: type 3 never advances the expected reference tag
   p_type3_ref_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CHECK && cfg.pi_type == 2'd3) |=> $stable(exp_ref));

   // R12: once an error is recorded it is not overwritten within the command
   p_first_error_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 3'd0 && !cmd_accept) |=> $stable(status));

   // R12: draining never returns to checking
   p_drain_no_check_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN) |=> (st != ST_CHECK));

endmodule

// File: tb/pi_verify_bench.sv
module pi_verify_bench;
   localparam int SB = 64;
   localparam int MB = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic [2:0]  cmd_chk = '0;
   logic [15:0] cmd_app_exp = '0;
   logic [15:0] cmd_app_msk = '0;
   logic [47:0] cmd_ref_start = '0;
   logic [63:0] cmd_slba = '0;
   logic [7:0]  cmd_nlb_m1 = '0;
   logic [1:0]  cmd_pi_type = '0;
   logic        cmd_fmt64 = 1'b0;
   logic        cmd_tuple_first = 1'b0;
   logic        in_vld = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        busy, done, no_retry;
   logic [2:0]  status;

   always #2 clk = ~clk;

   pi_verify u_pi_verify (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_chk(cmd_chk),
      .cmd_app_exp(cmd_app_exp), .cmd_app_msk(cmd_app_msk), .cmd_ref_start(cmd_ref_start),
      .cmd_slba(cmd_slba), .cmd_nlb_m1(cmd_nlb_m1), .cmd_pi_type(cmd_pi_type),
      .cmd_fmt64(cmd_fmt64), .cmd_tuple_first(cmd_tuple_first), .in_vld(in_vld),
      .in_byte(in_byte), .busy(busy), .done(done), .status(status), .no_retry(no_retry)
   );

   logic [7:0] dat [4][SB];
   logic [7:0] md  [4][MB];
   int n_cmp = 0;
   int n_bad = 0;

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   function automatic int toff_of(input bit f64, input bit first);
      return first ? 0 : (MB - (f64 ? 16 : 8));
   endfunction

   function automatic logic [15:0] s16(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c ^ {b, 8'h00};
      for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h8BB7) : (r << 1);
      return r;
   endfunction

   function automatic logic [63:0] s64(input logic [63:0] c, input logic [7:0] b);
      logic [63:0] r = c ^ {56'h0, b};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 64'h9A6C9329AC4BC9B5) : (r >> 1);
      return r;
   endfunction

   function automatic logic [63:0] guard_of(input int b, input bit f64, input bit first);
      int p = toff_of(f64, first);
      logic [15:0] c16 = '0;
      logic [63:0] c = '1;
      logic [63:0] r;
      if (!f64) begin
         for (int i = 0; i < SB; i++) c16 = s16(c16, dat[b][i]);
         for (int i = 0; i < p; i++)  c16 = s16(c16, md[b][i]);
         return {48'h0, c16};
      end
      for (int i = 0; i < SB; i++) c = s64(c, dat[b][i]);
      r = ~c;
      if (p > 0) begin
         c = r;
         for (int i = 0; i < p; i++) c = s64(c, md[b][i]);
         r = ~c;
      end
      return r;
   endfunction

   task automatic set_tuple(input int b, input bit f64, input bit first,
                            input logic [63:0] g, input logic [15:0] a, input logic [47:0] r);
      int o = toff_of(f64, first);
      if (f64) begin
         for (int k = 0; k < 8; k++) md[b][o+k] = g[63-8*k -: 8];
         md[b][o+8] = a[15:8];
         md[b][o+9] = a[7:0];
         for (int k = 0; k < 6; k++) md[b][o+10+k] = r[47-8*k -: 8];
      end else begin
         md[b][o]   = g[15:8];
         md[b][o+1] = g[7:0];
         md[b][o+2] = a[15:8];
         md[b][o+3] = a[7:0];
         for (int k = 0; k < 4; k++) md[b][o+4+k] = r[31-8*k -: 8];
      end
   endtask

   task automatic fill(input int b, input int seed, input bit f64, input bit first,
                       input logic [15:0] a, input logic [47:0] r, input bit zero);
      for (int i = 0; i < SB; i++) dat[b][i] = zero ? 8'h00 : 8'((seed * 7 + i * 13 + b * 5 + 1) & 255);
      for (int i = 0; i < MB; i++) md[b][i] = 8'((seed + i * 29 + 3) & 255);
      set_tuple(b, f64, first, guard_of(b, f64, first), a, r);
   endtask

   task automatic run(input logic [2:0] chk, input logic [15:0] a, input logic [15:0] msk,
                      input logic [47:0] r, input logic [63:0] slba, input int nb,
                      input logic [1:0] typ, input bit f64, input bit first);
      @(negedge clk);
      cmd_start = 1'b1; cmd_chk = chk; cmd_app_exp = a; cmd_app_msk = msk;
      cmd_ref_start = r; cmd_slba = slba; cmd_nlb_m1 = 8'(nb - 1);
      cmd_pi_type = typ; cmd_fmt64 = f64; cmd_tuple_first = first;
      for (int b = 0; b < nb; b++) begin
         for (int i = 0; i < SB + MB; i++) begin
            @(negedge clk);
            cmd_start = 1'b0;
            in_vld = 1'b1;
            in_byte = (i < SB) ? dat[b][i] : md[b][i-SB];
         end
      end
      @(negedge clk);
      in_vld = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 reset busy", busy, 0);
      check("R1 reset done", done, 0);
      check("R1 reset status", status, 0);
      check("R1 reset no_retry", no_retry, 0);
   endtask

   task automatic t_good_formats;
      for (int b = 0; b < 3; b++) fill(b, 11, 0, 0, 16'h1234, 48'(100 + b), 0);
      run(3'b111, 16'h1234, 16'hFFFF, 48'd100, 64'd100, 3, 2'd1, 0, 0);
      check("R2 crc16 tuple at end", status, 0);
      check("R12 done after last byte", done, 1);
      for (int b = 0; b < 2; b++) fill(b, 22, 1, 1, 16'hBEEF, 48'(5000 + b), 0);
      run(3'b111, 16'hBEEF, 16'hFFFF, 48'd5000, 64'd1, 2, 2'd2, 1, 1);
      check("R4 crc64 tuple first", status, 0);
      for (int b = 0; b < 2; b++) fill(b, 33, 1, 0, 16'h0042, 48'(7 + b), 0);
      run(3'b111, 16'h0042, 16'hFFFF, 48'd7, 64'd7, 2, 2'd1, 1, 0);
      check("R3 crc64 with metadata prefix", status, 0);
      fill(0, 44, 0, 1, 16'h0042, 48'd9, 0);
      run(3'b111, 16'h0042, 16'hFFFF, 48'd9, 64'd9, 1, 2'd1, 0, 1);
      check("R4 crc16 tuple first", status, 0);
   endtask

   task automatic t_priority;
      logic [63:0] g;
      for (int b = 0; b < 3; b++) fill(b, 5, 0, 0, 16'h1111, 48'(20 + b), 0);
      g = guard_of(1, 0, 0);
      set_tuple(1, 0, 0, g ^ 64'h1, 16'h2222, 48'd99);
      run(3'b111, 16'h1111, 16'hFFFF, 48'd20, 64'd20, 3, 2'd1, 0, 0);
      check("R5 guard before app and ref", status, 1);
      check("R12 drained to end", done, 1);
      run(3'b011, 16'h1111, 16'hFFFF, 48'd20, 64'd20, 3, 2'd1, 0, 0);
      check("R5 guard off, app reported", status, 2);
      run(3'b001, 16'h1111, 16'hFFFF, 48'd20, 64'd20, 3, 2'd1, 0, 0);
      check("R5 only ref enabled", status, 3);
      run(3'b000, 16'h1111, 16'hFFFF, 48'd20, 64'd20, 3, 2'd1, 0, 0);
      check("R5 no checks enabled", status, 0);
      for (int b = 0; b < 3; b++) fill(b, 6, 0, 0, 16'h1111, 48'(20 + b), 0);
      run(3'b111, 16'h1111, 16'hFFFF, 48'd20, 64'd20, 3, 2'd1, 0, 0);
      check("R12 stream aligned after drain", status, 0);
   endtask

   task automatic t_app_mask;
      fill(0, 7, 0, 0, 16'h12F4, 48'd3, 0);
      run(3'b111, 16'h1234, 16'hFF0F, 48'd3, 64'd3, 1, 2'd1, 0, 0);
      check("R6 masked bits ignored", status, 0);
      run(3'b111, 16'h1234, 16'hFFFF, 48'd3, 64'd3, 1, 2'd1, 0, 0);
      check("R6 unmasked difference", status, 2);
   endtask

   task automatic t_last_block_ref;
      for (int b = 0; b < 3; b++) fill(b, 8, 0, 0, 16'h5555, 48'(40 + b), 0);
      set_tuple(2, 0, 0, guard_of(2, 0, 0), 16'h5555, 48'd77);
      run(3'b111, 16'h5555, 16'hFFFF, 48'd40, 64'd40, 3, 2'd1, 0, 0);
      check("R9 ref error on final sector", status, 3);
      check("R12 done with final verdict", done, 1);
   endtask

   task automatic t_escape;
      logic [63:0] g;
      fill(0, 9, 0, 0, 16'hFFFF, 48'd0, 0);
      g = guard_of(0, 0, 0);
      set_tuple(0, 0, 0, g ^ 64'h1, 16'hFFFF, 48'd999);
      run(3'b111, 16'h1234, 16'hFFFF, 48'd50, 64'd50, 1, 2'd1, 0, 0);
      check("R7 type1 app escape", status, 0);
      set_tuple(0, 0, 0, g ^ 64'h1, 16'hFFFF, 48'h0000_1234_5678);
      run(3'b111, 16'h1234, 16'hFFFF, 48'd50, 64'd50, 1, 2'd3, 0, 0);
      check("R8 type3 needs ref ones too", status, 1);
      set_tuple(0, 0, 0, g ^ 64'h1, 16'h1234, 48'h0000_FFFF_FFFF);
      run(3'b111, 16'h1234, 16'hFFFF, 48'd50, 64'd50, 1, 2'd3, 0, 0);
      check("R8 type3 needs app ones too", status, 1);
      fill(0, 10, 1, 0, 16'hFFFF, 48'd0, 0);
      g = guard_of(0, 1, 0);
      set_tuple(0, 1, 0, ~g, 16'hFFFF, 48'hFFFF_FFFF_FFFF);
      run(3'b111, 16'h1234, 16'hFFFF, 48'd50, 64'd50, 1, 2'd3, 1, 0);
      check("R8 type3 48-bit escape", status, 0);
   endtask

   task automatic t_ref_step;
      for (int b = 0; b < 2; b++) fill(b, 12, 0, 0, 16'h0001, 48'h77, 0);
      run(3'b111, 16'h0001, 16'hFFFF, 48'h77, 64'd0, 2, 2'd3, 0, 0);
      check("R9 type3 ref constant", status, 0);
      run(3'b111, 16'h0001, 16'hFFFF, 48'h77, 64'd0, 2, 2'd2, 0, 0);
      check("R9 type2 ref advances", status, 3);
   endtask

   task automatic t_prevalid;
      for (int b = 0; b < 2; b++) fill(b, 13, 0, 0, 16'h0A0A, 48'(11 + b), 0);
      run(3'b111, 16'h0A0A, 16'hFFFF, 48'd11, 64'd10, 2, 2'd1, 0, 0);
      check("R10 seed mismatch status", status, 4);
      check("R10 seed mismatch no_retry", no_retry, 1);
      check("R10 bytes drained", done, 1);
      run(3'b110, 16'h0A0A, 16'hFFFF, 48'd11, 64'd10, 2, 2'd1, 0, 0);
      check("R10 ref check off skips seed test", status, 0);
      check("R10 no_retry cleared", no_retry, 0);
      for (int b = 0; b < 2; b++) fill(b, 14, 1, 0, 16'h0A0A, 48'(9 + b), 0);
      run(3'b111, 16'h0A0A, 16'hFFFF, 48'd9, (64'd1 << 50) | 64'd9, 2, 2'd1, 1, 0);
      check("R10 only low 48 bits compared", status, 0);
   endtask

   task automatic t_zero_sector;
      fill(0, 15, 1, 0, 16'h0C0C, 48'd0, 1);
      set_tuple(0, 1, 0, 64'h0, 16'h0C0C, 48'd0);
      run(3'b111, 16'h0C0C, 16'hFFFF, 48'd0, 64'd0, 1, 2'd1, 1, 0);
      check("R11 zero sector at lba 0 forgiven", status, 0);
      run(3'b111, 16'h0C0C, 16'hFFFF, 48'd0, 64'd3, 1, 2'd2, 1, 0);
      check("R11 nonzero lba not forgiven", status, 1);
      fill(0, 16, 1, 0, 16'h0C0C, 48'd0, 0);
      fill(1, 16, 1, 0, 16'h0C0C, 48'd1, 1);
      set_tuple(1, 1, 0, 64'h0, 16'h0C0C, 48'd1);
      run(3'b111, 16'h0C0C, 16'hFFFF, 48'd0, 64'd0, 2, 2'd1, 1, 0);
      check("R11 second sector not forgiven", status, 1);
   endtask

   task automatic t_idle_hold;
      logic [2:0] s;
      s = status;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         in_vld = 1'b1;
         in_byte = 8'(i * 37 + 1);
      end
      @(negedge clk);
      in_vld = 1'b0;
      check("R1 status held while idle", status, s);
      check("R1 done held while idle", done, 1);
      fill(0, 17, 0, 0, 16'h3333, 48'd4, 0);
      run(3'b111, 16'h3333, 16'hFFFF, 48'd4, 64'd4, 1, 2'd1, 0, 0);
      check("R1 idle bytes ignored", status, 0);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_good_formats();
      t_priority();
      t_app_mask();
      t_last_block_ref();
      t_escape();
      t_ref_step();
      t_prevalid();
      t_zero_sector();
      t_idle_hold();
      summary();
   end

endmodule